// File: doc/BRIEF.md
# Scrolled Background Address Generator

This block tracks the video beam and turns it into the address of the background name-table entry for the tile under the current pixel. A clock divider produces one dot tick every `DOT_DIV` master clocks. A horizontal counter steps through one full line of 416 dots. A vertical counter steps through a full frame of 262 lines and advances only when the line wraps.

The CPU reaches the block through a small port interface that has a 4-bit port number, a write enable and a 16-bit write word. A write to port 0xC loads the vertical scroll word. A write to port 0xD loads the horizontal scroll word. Reading those same two ports returns the live beam position instead of the scroll values.

Horizontal and vertical coarse tile indices come from adding each scroll word to the beam position. Each of the five upper vertical coarse bits can instead be pinned to the raw register bit by its own mask bit. The two coarse indices are packed into a word-aligned name-table address in the lower half of video memory.

Top module: `bg_scroll_addr`

## Requirements
- R1: The horizontal position advances by one exactly once every `DOT_DIV` (default 4) clock cycles, counted from reset release. The first step lands on the 4th rising edge after release.
- R2: The horizontal position counts 0 to 415 and then returns to 0 on the next dot tick.
- R3: The vertical position counts 0 to 261. It steps only on the dot tick where the horizontal position wraps, and it returns to 0 after 261.
- R4: While reset (active-low `rst_n`) is asserted, both positions and both scroll registers are zero. Reads of ports 0xC and 0xD return 0x0000, and `ntAddr` is 0x0000.
- R5: A write with `wrEn`=1 to port 0xD loads the horizontal scroll register from bits [8:0] of `wrData`. Bits [15:9] have no effect on any output.
- R6: A write with `wrEn`=1 to port 0xC loads all 16 bits of the vertical scroll register. Bits [15:11] are mask bits, [10:3] are coarse bits and [2:0] are fine bits.
- R7: With `portAddr`=0xC, `rdData` is the vertical position, zero-extended. With 0xD it is the horizontal position, zero-extended. For any other port it is 0x0000. The read path is combinational.
- R8: A write to any other port, or a cycle with `wrEn`=0, leaves both scroll registers unchanged.
- R9: The horizontal coarse index is bits [8:3] of (horizontal scroll[8:0] + horizontal position), taken modulo 512.
- R10: The vertical coarse index is bits [10:3] of (vertical scroll[10:0] + vertical position), taken modulo 2048. The exception is coarse bit k (k = 3..7): when mask bit k+8 of the register is 1, that bit is taken from register bit k+3 instead.
- R11: `ntAddr` = {1'b0, vertical coarse[7:0], horizontal coarse[5:0], 1'b0}. It is combinational from the current positions and scroll registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| portAddr | input | 4 | CPU port number for reads and writes |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | 16 | Write word |
| rdData | output | 16 | Read word (beam position for ports 0xC/0xD) |
| ntAddr | output | 16 | Name-table fetch address for the current pixel |

## Verification
The assertions assume a few things about the inputs:
- `portAddr` and `wrData` are always at known values.
- A write is a single-cycle `wrEn` pulse whose port number and data are stable at the capturing edge.
- Reset is applied before the first dot tick.

The stimulus respects these assumptions by changing every input only on falling edges and dropping `wrEn` one cycle after raising it. The vertical-scroll load property compares against the previous write word, so back-to-back writes to different ports stay legal. A second instance runs with a divide of one so that a full frame wrap fits in the run.

// File: rtl/bg_scroll_pkg.sv
package bg_scroll_pkg;
  typedef struct packed {
    logic wrVScroll;
    logic wrHScroll;
  } scrollStrobe_t;
endpackage

// File: rtl/beam_ctrl.sv
module beam_ctrl
  import bg_scroll_pkg::*;
#(
  parameter int H_TOTAL = 416,
  parameter int V_TOTAL = 262,
  parameter int DOT_DIV = 4,
  parameter int PORT_W = 4,
  parameter logic [PORT_W-1:0] VSCROLL_PORT = 4'hC,
  parameter logic [PORT_W-1:0] HSCROLL_PORT = 4'hD,
  localparam int H_W = $clog2(H_TOTAL),
  localparam int V_W = $clog2(V_TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] portAddr,
  input  logic              wrEn,
  output scrollStrobe_t     strobe,
  output logic [H_W-1:0]    hPos,
  output logic [V_W-1:0]    vPos
);
  localparam int DIV_W = (DOT_DIV > 1) ? $clog2(DOT_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DOT_DIV - 1);
  localparam logic [H_W-1:0] H_LAST = H_W'(H_TOTAL - 1);
  localparam logic [V_W-1:0] V_LAST = V_W'(V_TOTAL - 1);

  logic [DIV_W-1:0] divCnt;
  logic dotTick;
  logic hLast;

  assign dotTick = (divCnt == DIV_LAST);
  assign hLast   = (hPos == H_LAST);

  // Dot divider
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       divCnt <= '0;
    else if (dotTick) divCnt <= '0;
    else              divCnt <= divCnt + 1'b1;
  end

  // Horizontal beam counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hPos <= '0;
    else if (dotTick) hPos <= hLast ? '0 : hPos + 1'b1;
  end

  // Vertical beam counter, steps on line wrap
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                vPos <= '0;
    else if (dotTick && hLast) vPos <= (vPos == V_LAST) ? '0 : vPos + 1'b1;
  end

  // Write decode into strobes for the datapath
  always_comb begin
    strobe.wrVScroll = wrEn && (portAddr == VSCROLL_PORT);
    strobe.wrHScroll = wrEn && (portAddr == HSCROLL_PORT);
  end

  // R1
  hpos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dotTick |=> $stable(hPos));
  // R2
  hpos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hPos <= H_LAST);
  // R2
  hpos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dotTick && hPos == H_LAST) |=> (hPos == '0));
  // R3
  vpos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dotTick && hPos == H_LAST) |=> $stable(vPos));
  // R3
  vpos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vPos <= V_LAST);
endmodule

// File: rtl/scroll_datapath.sv
module scroll_datapath
  import bg_scroll_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PORT_W = 4,
  parameter logic [PORT_W-1:0] VSCROLL_PORT = 4'hC,
  parameter logic [PORT_W-1:0] HSCROLL_PORT = 4'hD,
  parameter int H_W = 9,
  parameter int V_W = 9,
  parameter int FINE_W = 3,
  parameter int H_COARSE_W = 6,
  parameter int V_COARSE_W = 8,
  parameter int MASK_N = 5,
  localparam int HS_W = H_COARSE_W + FINE_W,
  localparam int VS_SUM_W = V_COARSE_W + FINE_W,
  localparam int VS_W = VS_SUM_W + MASK_N,
  localparam int FREE_N = V_COARSE_W - MASK_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  scrollStrobe_t     strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PORT_W-1:0] portAddr,
  input  logic [H_W-1:0]    hPos,
  input  logic [V_W-1:0]    vPos,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ntAddr
);
  logic [HS_W-1:0] hScroll;
  logic [VS_W-1:0] vScroll;
  logic [HS_W-1:0] hSum;
  logic [VS_SUM_W-1:0] vSum;
  logic [H_COARSE_W-1:0] hCoarse;
  logic [V_COARSE_W-1:0] vCoarse;
  logic unusedHiBits;

  assign unusedHiBits = ^wrData[DATA_W-1:HS_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hScroll <= '0;
    else if (strobe.wrHScroll)  hScroll <= wrData[HS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 vScroll <= '0;
    else if (strobe.wrVScroll)  vScroll <= wrData[VS_W-1:0];
  end

  // Sums of scroll and beam position
  assign hSum = hScroll + HS_W'(hPos);
  assign vSum = vScroll[VS_SUM_W-1:0] + VS_SUM_W'(vPos);

  assign hCoarse = hSum[FINE_W +: H_COARSE_W];
  assign vCoarse[FREE_N-1:0] = vSum[FINE_W +: FREE_N];

  // Per-bit choice between raw register bit and summed bit
  for (genvar i = 0; i < MASK_N; i++) begin : g_mask
    assign vCoarse[FREE_N+i] = vScroll[VS_SUM_W+i] ? vScroll[FINE_W+FREE_N+i]
                                                   : vSum[FINE_W+FREE_N+i];
  end

  assign ntAddr = DATA_W'({1'b0, vCoarse, hCoarse, 1'b0});

  always_comb begin
    if (portAddr == VSCROLL_PORT)      rdData = DATA_W'(vPos);
    else if (portAddr == HSCROLL_PORT) rdData = DATA_W'(hPos);
    else                               rdData = '0;
  end

  // R8
  hscroll_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.wrHScroll |=> $stable(hScroll));
  // R8
  vscroll_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.wrVScroll |=> $stable(vScroll));
  // R6
  vscroll_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrVScroll |=> (vScroll == $past(wrData[VS_W-1:0])));
  // R11
  addr_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ntAddr[0] == 1'b0) && (ntAddr[DATA_W-1] == 1'b0));
endmodule

// File: rtl/bg_scroll_addr.sv
module bg_scroll_addr
  import bg_scroll_pkg::*;
#(
  parameter int H_TOTAL = 416,
  parameter int V_TOTAL = 262,
  parameter int DOT_DIV = 4,
  parameter int DATA_W = 16,
  parameter int PORT_W = 4,
  parameter logic [PORT_W-1:0] VSCROLL_PORT = 4'hC,
  parameter logic [PORT_W-1:0] HSCROLL_PORT = 4'hD,
  localparam int H_W = $clog2(H_TOTAL),
  localparam int V_W = $clog2(V_TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] portAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ntAddr
);
  scrollStrobe_t strobe;
  logic [H_W-1:0] hPos;
  logic [V_W-1:0] vPos;

  beam_ctrl #(
    .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .DOT_DIV(DOT_DIV),
    .PORT_W(PORT_W), .VSCROLL_PORT(VSCROLL_PORT), .HSCROLL_PORT(HSCROLL_PORT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .portAddr(portAddr), .wrEn(wrEn),
    .strobe(strobe), .hPos(hPos), .vPos(vPos)
  );

  scroll_datapath #(
    .DATA_W(DATA_W), .PORT_W(PORT_W),
    .VSCROLL_PORT(VSCROLL_PORT), .HSCROLL_PORT(HSCROLL_PORT),
    .H_W(H_W), .V_W(V_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(wrData),
    .portAddr(portAddr), .hPos(hPos), .vPos(vPos),
    .rdData(rdData), .ntAddr(ntAddr)
  );
endmodule

// File: tb/bg_scroll_addr_bench.sv
`timescale 1ns/1ps
module bg_scroll_addr_bench;
  localparam int HT = 416;
  localparam int VT = 262;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] portAddr = 4'h0;
  logic wrEn = 1'b0;
  logic [15:0] wrData = 16'h0;
  logic [15:0] rdData, ntAddr, rdDataF, ntAddrF;

  int checks = 0;
  int fails = 0;
  int nEdges = 0;
  logic [15:0] curV = 16'h0;
  logic [15:0] curH = 16'h0;

  always #4 clk = ~clk;

  always @(posedge clk) if (rst_n) nEdges <= nEdges + 1;

  bg_scroll_addr u_bg_scroll_addr (
    .clk(clk), .rst_n(rst_n), .portAddr(portAddr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .ntAddr(ntAddr));

  bg_scroll_addr #(.DOT_DIV(1)) u_bg_scroll_addr_fast (
    .clk(clk), .rst_n(rst_n), .portAddr(portAddr), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdDataF), .ntAddr(ntAddrF));

  function automatic int modelH(int n, int d);
    return (n / d) % HT;
  endfunction

  function automatic int modelV(int n, int d);
    return (n / (d * HT)) % VT;
  endfunction

  function automatic logic [15:0] expAddr(logic [15:0] vs, logic [15:0] hs, int h, int v);
    logic [10:0] vsum;
    logic [8:0] hsum;
    logic [7:0] vc;
    vsum = vs[10:0] + 11'(v);
    vc = vsum[10:3];
    for (int k = 3; k < 8; k++) if (vs[k+8]) vc[k] = vs[k+3];
    hsum = hs[8:0] + 9'(h);
    return {1'b0, vc, hsum[8:3], 1'b0};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (edge %0d)", req, act, exp, nEdges);
    end
  endtask

  task automatic readPort(logic [3:0] p, output logic [15:0] val);
    portAddr = p;
    #1;
    val = rdData;
  endtask

  task automatic writePort(logic [3:0] p, logic [15:0] d, logic en);
    @(negedge clk);
    portAddr = p; wrData = d; wrEn = en;
    @(negedge clk);
    wrEn = 1'b0;
    if (en && p == 4'hC) curV = d;
    if (en && p == 4'hD) curH = d;
  endtask

  task automatic checkAddr(string req);
    #1;
    chk(req, ntAddr, expAddr(curV, curH, modelH(nEdges, DIV), modelV(nEdges, DIV)));
  endtask

  task automatic waitEdges(int target);
    while (nEdges < target) @(negedge clk);
  endtask

  task automatic testReset();
    logic [15:0] r;
    repeat (3) @(negedge clk);
    readPort(4'hC, r); chk("R4 vpos in reset", r, 16'h0);
    readPort(4'hD, r); chk("R4 hpos in reset", r, 16'h0);
    chk("R4 ntAddr in reset", ntAddr, 16'h0);
    rst_n = 1'b1;
  endtask

  task automatic testDivider();
    logic [15:0] r;
    waitEdges(3); readPort(4'hD, r); chk("R1 before 4th edge", r, 16'd0);
    waitEdges(4); readPort(4'hD, r); chk("R1 at 4th edge", r, 16'd1);
    waitEdges(7); readPort(4'hD, r); chk("R1 hold", r, 16'd1);
    waitEdges(8); readPort(4'hD, r); chk("R1 second step", r, 16'd2);
    waitEdges(41); readPort(4'hD, r); chk("R1 later", r, 16'(modelH(41, DIV)));
    checkAddr("R11 zero scroll");
  endtask

  task automatic testHScroll();
    logic [15:0] a;
    writePort(4'hD, 16'h0135, 1'b1);
    checkAddr("R9 hscroll 0x135");
    writePort(4'hD, 16'h01F9, 1'b1);
    checkAddr("R9 hscroll wraps mod 512");
    writePort(4'hD, 16'h0035, 1'b1);
    waitEdges(200);
    a = ntAddr;
    writePort(4'hD, 16'hFE35, 1'b1);
    #1;
    chk("R5 upper hscroll bits ignored", ntAddr, a);
    checkAddr("R5 hscroll model");
  endtask

  task automatic testVScroll();
    writePort(4'hC, 16'h02A5, 1'b1);
    checkAddr("R6 vscroll load");
    writePort(4'hC, 16'h07FF, 1'b1);
    checkAddr("R10 vscroll no mask");
  endtask

  task automatic testIgnored();
    logic [15:0] a, r;
    writePort(4'hD, 16'h0000, 1'b1);
    writePort(4'hC, 16'h0000, 1'b1);
    writePort(4'hE, 16'h07FF, 1'b1);
    checkAddr("R8 other port write ignored");
    writePort(4'hC, 16'h03F0, 1'b0);
    writePort(4'hD, 16'h01F0, 1'b0);
    a = ntAddr;
    checkAddr("R8 write without wrEn ignored");
    chk("R8 addr unchanged zero scroll", a, expAddr(16'h0, 16'h0, modelH(nEdges, DIV), modelV(nEdges, DIV)));
    readPort(4'hE, r); chk("R7 other port reads zero", r, 16'h0);
    readPort(4'h0, r); chk("R7 port 0 reads zero", r, 16'h0);
  endtask

  task automatic testLineWrap();
    logic [15:0] r;
    waitEdges(HT * DIV - 1);
    readPort(4'hD, r); chk("R2 last dot", r, 16'd415);
    readPort(4'hC, r); chk("R3 line 0", r, 16'd0);
    waitEdges(HT * DIV);
    readPort(4'hD, r); chk("R2 wrap to 0", r, 16'd0);
    readPort(4'hC, r); chk("R3 step on wrap", r, 16'd1);
  endtask

  task automatic testMask();
    writePort(4'hC, 16'h07FF, 1'b1);
    checkAddr("R10 unmasked carry");
    writePort(4'hC, 16'hFFFF, 1'b1);
    checkAddr("R10 all masked");
    chk("R10 all masked coarse", ntAddr[14:7], 8'hF8);
    writePort(4'hC, 16'h57FF, 1'b1);
    checkAddr("R10 partial mask");
    waitEdges(50000);
    checkAddr("R10 mid frame partial mask");
    writePort(4'hD, 16'h0123, 1'b1);
    writePort(4'hC, 16'h9A47, 1'b1);
    checkAddr("R11 mixed scroll mid frame");
  endtask

  task automatic testFrameWrap();
    logic [15:0] r;
    waitEdges(HT * VT - 1);
    portAddr = 4'hC; #1; chk("R3 last line", rdDataF, 16'd261);
    portAddr = 4'hD; #1; chk("R2 last dot fast", rdDataF, 16'd415);
    waitEdges(HT * VT);
    portAddr = 4'hC; #1; chk("R3 frame wrap", rdDataF, 16'd0);
    portAddr = 4'hD; #1; chk("R2 dot wrap fast", rdDataF, 16'd0);
    readPort(4'hC, r); chk("R7 vpos read main", r, 16'(modelV(nEdges, DIV)));
  endtask

  initial begin
    #(150000 * 8);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    testReset();
    testDivider();
    testHScroll();
    testVScroll();
    testIgnored();
    testLineWrap();
    testMask();
    testFrameWrap();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule